// File: doc/BRIEF.md
# Smart-Card Serial Transceiver with Parity-Error Signaling

This block is a half-duplex asynchronous transceiver for a smart-card link in which transmit and receive share one open-drain wire. A host writes a byte into a one-entry holding register; on the next sub-bit tick of the baud generator the byte moves into a shift register and goes out as a start bit, eight data bits (least significant first), a parity bit and a stop bit. Because the wire is shared, the transmitter also hears the line. It samples the line in the middle of its own stop bit. A low level there means the far end rejected the parity, and the block sets an error-signal flag.

The receive side oversamples the wire sixteen times per bit. It confirms a start edge at mid-bit and shifts in the data. When the parity is wrong, it pulls the wire low for the whole stop bit that follows. The block then delivers the byte and sets a sticky parity-error flag. The bit time is sixteen times the divider value plus one, multiplied by a prescale of 1, 8 or 32 system clocks. Each direction has an interrupt request. For the transmit interrupt, the host chooses whether it fires when the holding register empties or when the frame has left the wire.

Top module: `scard_uart`

## Requirements
- R1: A bit lasts exactly 16*(n+1)*D clocks, where n is the divider register (address 2) and D is 1, 8 or 32 for control field bits [5:4] = 0, 1, 2 (3 acts as 32).
- R2: A transmitted frame on line_out is 0 (start), data bit 0 up to bit 7, parity, 1 (stop). Parity equals the XOR of the data when control bit 2 is 0 and its inverse when control bit 2 is 1.
- R3: With control bit 0 (transmit enable) set, a byte written to address 0 starts its start bit no more than (n+1)*D+1 clocks after the write.
- R4: Status bit 0 (holding register empty) is 1 while the frame is being shifted out. Status bit 1 (shift register empty) is 0 during the frame and returns to 1 after the stop bit.
- R5: Control bit 3 selects the transmit interrupt cause. With 1, tx_irq rises only after the stop bit ends. With 0, tx_irq rises when the byte leaves the holding register.
- R6: A low level on line_in in the middle of the transmitter's stop bit sets status bit 4. Writing 1 to status bit 4 at address 3 clears it. A frame with the wire left high during its stop bit leaves bit 4 at 0.
- R7: With control bit 1 (receive enable) set, a received frame sets status bit 2 and raises rx_irq. It makes the byte readable at address 0, and a read of address 0 clears status bit 2.
- R8: A received frame whose parity is wrong makes line_out low in the middle of its stop bit and sets the sticky status bit 3, which writing 1 to bit 3 clears. A frame with correct parity leaves line_out high.
- R9: A low pulse on the wire shorter than half a bit does not start a reception.
- R10: tx_irq and rx_irq clear on tx_irq_ack and rx_irq_ack respectively, or on writing 1 to status bit 5 (transmit) or bit 6 (receive).
- R11: After reset the status register reads 0x03, line_out is 1 and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (read of address 0 consumes the byte) |
| host_addr | input | 2 | Register address: 0 data, 1 control, 2 divider, 3 status |
| host_wdata | input | HOST_W | Write data |
| host_rdata | output | HOST_W | Read data for host_addr |
| tx_irq_ack | input | 1 | Acknowledge for the transmit interrupt |
| rx_irq_ack | input | 1 | Acknowledge for the receive interrupt |
| line_in | input | 1 | Level of the shared wire |
| line_out | output | 1 | Open-drain drive to the shared wire; 0 pulls low |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest situation to reach from the ports is the error signal caught by the transmitter: something must pull the wire low inside the transmitter's own stop bit and release it before the next frame. The bench plays the far end. It finds the falling start edge on line_out, counts whole bit times from it, and pulls line_in low from one eighth to seven eighths of the stop bit. It also sends frames with deliberately wrong parity and checks that the block's own drive appears at mid stop bit, and it sends a start pulse too short to survive the mid-bit recheck.

// File: rtl/scard_pkg.sv
package scard_pkg;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_DIV  = 2'd2;
   localparam logic [1:0] ADDR_STAT = 2'd3;

   localparam int ST_BUF_EMPTY = 0;
   localparam int ST_REG_EMPTY = 1;
   localparam int ST_RX_DONE   = 2;
   localparam int ST_PAR_ERR   = 3;
   localparam int ST_ERR_SIG   = 4;
   localparam int ST_TX_IRQ    = 5;
   localparam int ST_RX_IRQ    = 6;
   localparam int ST_BITS      = 7;

   typedef struct packed {
      logic [1:0] clk_sel;
      logic       cause_done;
      logic       odd_par;
      logic       rx_en;
      logic       tx_en;
   } ctrl_t;

endpackage

// File: rtl/scard_baud.sv
module scard_baud #(
   parameter int DIV_W = 8,
   parameter int PRE_1 = 1,
   parameter int PRE_2 = 8,
   parameter int PRE_3 = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       clk_sel,
   input  logic [DIV_W-1:0] divisor,
   output logic             sub_tick
);
   localparam int PW = $clog2(PRE_3);

   generate
      if (PRE_1 < 1 || PRE_2 <= PRE_1 || PRE_3 <= PRE_2)
         $error("scard_baud: prescales must rise strictly from at least 1");
      if (DIV_W < 1)
         $error("scard_baud: DIV_W must be positive");
   endgenerate

   logic [PW-1:0]    pre_cnt, lim_m1;
   logic [DIV_W-1:0] div_cnt;
   logic             cnt_tick;

   always_comb begin
      case (clk_sel)
         2'd0:    lim_m1 = PW'(PRE_1 - 1);
         2'd1:    lim_m1 = PW'(PRE_2 - 1);
         default: lim_m1 = PW'(PRE_3 - 1);
      endcase
   end

   assign cnt_tick = (pre_cnt >= lim_m1);
   assign sub_tick = cnt_tick && (div_cnt >= divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= cnt_tick ? '0 : pre_cnt + 1'b1;
         if (cnt_tick)
            div_cnt <= (div_cnt >= divisor) ? '0 : div_cnt + 1'b1;
      end
   end

   // R1: the divider only advances on a prescaled count
   a_r1_div_on_count: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_tick |=> $stable(div_cnt));

endmodule

// File: rtl/scard_tx.sv
module scard_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              tx_en,
   input  logic              odd_par,
   input  logic              wr_buf,
   input  logic [DATA_W-1:0] wdata,
   input  logic              line_in,
   output logic              tx_line,
   output logic              buf_empty,
   output logic              reg_empty,
   output logic              load,
   output logic              done,
   output logic              err_seen
);
   localparam int NB    = DATA_W + 3;
   localparam int IDX_W = $clog2(NB);
   localparam int SUB_W = $clog2(OVS);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0)
         $error("scard_tx: OVS must be a power of two, at least 4");
   endgenerate

   logic [DATA_W-1:0] buf_q;
   logic              buf_full, busy;
   logic [NB-1:0]     shreg;
   logic [IDX_W-1:0]  idx;
   logic [SUB_W-1:0]  sub;
   logic              last_sub, in_stop;

   assign last_sub  = (sub == SUB_W'(OVS - 1));
   assign in_stop   = (idx == IDX_W'(NB - 1));
   assign load      = !busy && buf_full && tx_en && sub_tick;
   assign done      = busy && sub_tick && last_sub && in_stop;
   assign err_seen  = busy && sub_tick && in_stop && (sub == SUB_W'(OVS / 2)) && !line_in;
   assign tx_line   = busy ? shreg[0] : 1'b1;
   assign buf_empty = !buf_full;
   assign reg_empty = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q    <= '0;
         buf_full <= 1'b0;
         busy     <= 1'b0;
         shreg    <= '1;
         idx      <= '0;
         sub      <= '0;
      end else begin
         if (wr_buf) begin
            buf_q    <= wdata;
            buf_full <= 1'b1;
         end else if (load) begin
            buf_full <= 1'b0;
         end
         if (load) begin
            shreg <= {1'b1, (^buf_q) ^ odd_par, buf_q, 1'b0};
            busy  <= 1'b1;
            idx   <= '0;
            sub   <= '0;
         end else if (busy && sub_tick) begin
            sub <= sub + 1'b1;
            if (last_sub) begin
               if (in_stop) begin
                  busy <= 1'b0;
               end else begin
                  idx   <= idx + 1'b1;
                  shreg <= {1'b1, shreg[NB-1:1]};
               end
            end
         end
      end
   end

   // R2: every frame opens with a low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx_line);
   // R1: the bit position moves only on a sub-bit tick
   a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sub_tick && !load) |=> ($stable(idx) && $stable(sub)));
   // R4: the holding register empties only into a frame in progress
   a_r4_buf_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_full) |-> busy);

endmodule

// File: rtl/scard_rx.sv
module scard_rx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              rx_en,
   input  logic              odd_par,
   input  logic              line_in,
   output logic              drive_low,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bad
);
   localparam int NB    = DATA_W + 3;
   localparam int IDX_W = $clog2(NB);
   localparam int SUB_W = $clog2(OVS);
   localparam int MID   = OVS / 2 - 1;

   logic             active;
   logic [IDX_W-1:0] idx;
   logic [SUB_W-1:0] sub;
   logic             last_sub, at_mid, in_stop;

   assign last_sub = (sub == SUB_W'(OVS - 1));
   assign at_mid   = (sub == SUB_W'(MID));
   assign in_stop  = (idx == IDX_W'(NB - 1));
   assign done     = active && sub_tick && last_sub && in_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         idx       <= '0;
         sub       <= '0;
         data      <= '0;
         par_bad   <= 1'b0;
         drive_low <= 1'b0;
      end else if (!active) begin
         if (sub_tick && rx_en && !line_in) begin
            active  <= 1'b1;
            idx     <= '0;
            sub     <= SUB_W'(1);
            par_bad <= 1'b0;
         end
      end else if (sub_tick) begin
         sub <= sub + 1'b1;
         if (at_mid) begin
            if (idx == '0) begin
               if (line_in) active <= 1'b0;
            end else if (idx <= IDX_W'(DATA_W)) begin
               data <= {line_in, data[DATA_W-1:1]};
            end else if (idx == IDX_W'(DATA_W + 1)) begin
               par_bad <= line_in ^ (^data) ^ odd_par;
            end
         end
         if (last_sub) begin
            if (in_stop) begin
               active    <= 1'b0;
               drive_low <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
               if (idx == IDX_W'(DATA_W + 1)) drive_low <= par_bad;
            end
         end
      end
   end

   // R8: the error drive starts only for a frame whose parity failed
   a_r8_drive_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> par_bad);
   // R8: the error drive never outlasts its frame
   a_r8_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |-> active);

endmodule

// File: rtl/scard_uart.sv
module scard_uart #(
   parameter int HOST_W = 8,
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              tx_irq_ack,
   input  logic              rx_irq_ack,
   input  logic              line_in,
   output logic              line_out,
   output logic              tx_irq,
   output logic              rx_irq
);
   import scard_pkg::*;

   generate
      if (HOST_W < ST_BITS || DATA_W > HOST_W || DIV_W > HOST_W)
         $error("scard_uart: host width too narrow for registers");
   endgenerate

   ctrl_t             cfg;
   logic [DIV_W-1:0]  divisor;
   logic [DATA_W-1:0] rx_buf, rx_data;
   logic              rx_done, par_err, err_sig;
   logic              sub_tick, tx_line, buf_empty, reg_empty;
   logic              tx_load, tx_done, tx_err, drive_low, rx_fin, rx_bad;
   logic              wr_data, wr_stat, rd_data, tx_set;
   logic [ST_BITS-1:0] status;

   assign wr_data = host_wr && (host_addr == ADDR_DATA);
   assign wr_stat = host_wr && (host_addr == ADDR_STAT);
   assign rd_data = host_rd && (host_addr == ADDR_DATA);
   assign tx_set  = cfg.cause_done ? tx_done : tx_load;

   scard_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .clk_sel(cfg.clk_sel),
      .divisor(divisor), .sub_tick(sub_tick));

   scard_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .tx_en(cfg.tx_en),
      .odd_par(cfg.odd_par), .wr_buf(wr_data), .wdata(host_wdata[DATA_W-1:0]),
      .line_in(line_in), .tx_line(tx_line), .buf_empty(buf_empty),
      .reg_empty(reg_empty), .load(tx_load), .done(tx_done), .err_seen(tx_err));

   scard_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .rx_en(cfg.rx_en),
      .odd_par(cfg.odd_par), .line_in(line_in), .drive_low(drive_low),
      .done(rx_fin), .data(rx_data), .par_bad(rx_bad));

   assign line_out = tx_line & ~drive_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         divisor <= '0;
         rx_buf  <= '0;
         rx_done <= 1'b0;
         par_err <= 1'b0;
         err_sig <= 1'b0;
         tx_irq  <= 1'b0;
         rx_irq  <= 1'b0;
      end else begin
         if (host_wr && host_addr == ADDR_CTRL) cfg     <= ctrl_t'(host_wdata[5:0]);
         if (host_wr && host_addr == ADDR_DIV)  divisor <= host_wdata[DIV_W-1:0];
         if (rx_fin) rx_buf <= rx_data;
         rx_done <= rx_fin | (rx_done & ~rd_data);
         par_err <= (rx_fin & rx_bad) | (par_err & ~(wr_stat & host_wdata[ST_PAR_ERR]));
         err_sig <= tx_err | (err_sig & ~(wr_stat & host_wdata[ST_ERR_SIG]));
         tx_irq  <= tx_set | (tx_irq & ~(tx_irq_ack | (wr_stat & host_wdata[ST_TX_IRQ])));
         rx_irq  <= rx_fin | (rx_irq & ~(rx_irq_ack | (wr_stat & host_wdata[ST_RX_IRQ])));
      end
   end

   always_comb begin
      status = '0;
      status[ST_BUF_EMPTY] = buf_empty;
      status[ST_REG_EMPTY] = reg_empty;
      status[ST_RX_DONE]   = rx_done;
      status[ST_PAR_ERR]   = par_err;
      status[ST_ERR_SIG]   = err_sig;
      status[ST_TX_IRQ]    = tx_irq;
      status[ST_RX_IRQ]    = rx_irq;
      case (host_addr)
         ADDR_DATA: host_rdata = HOST_W'(rx_buf);
         ADDR_CTRL: host_rdata = HOST_W'(cfg);
         ADDR_DIV:  host_rdata = HOST_W'(divisor);
         default:   host_rdata = HOST_W'(status);
      endcase
   end

   // R7: reading the byte consumes the receive-complete flag
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_fin) |=> !rx_done);
   // R5: buffer-empty cause raises the request at the move into the shift register
   a_r5_cause_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !cfg.cause_done) |=> tx_irq);
   // R10: an acknowledge drops the request unless a new cause arrives
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq_ack && !tx_set) |=> !tx_irq);

endmodule

// File: tb/scard_uart_tb.sv
module scard_uart_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       tx_irq_ack = 1'b0, rx_irq_ack = 1'b0;
   logic       card_line = 1'b1;
   logic       line_in, line_out, tx_irq, rx_irq;

   int checks = 0, errors = 0;
   bit finished = 0;
   int lowcnt = 0, low_width = 0;
   bit arm = 0;

   always #4 clk = ~clk;

   assign line_in = line_out & card_line;

   scard_uart u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_irq_ack(tx_irq_ack), .rx_irq_ack(rx_irq_ack), .line_in(line_in),
      .line_out(line_out), .tx_irq(tx_irq), .rx_irq(rx_irq));

   // width of the first low stretch on line_out after arming
   always @(negedge clk) begin
      if (line_out == 1'b0) lowcnt++;
      else begin
         if (lowcnt > 0 && arm) begin
            low_width = lowcnt;
            arm = 0;
         end
         lowcnt = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   function automatic logic [10:0] frame_of(input logic [7:0] d, input bit odd);
      return {1'b1, (^d) ^ odd, d, 1'b0};
   endfunction

   function automatic int first_low(input logic [7:0] d, input int t);
      int n = 1;
      for (int i = 0; i < 8; i++) begin
         if (d[i]) break;
         n++;
      end
      return n * t;
   endfunction

   task automatic capture(input int t, input int lim, input bit inject,
                          output logic [10:0] bits, output int lat,
                          output logic [7:0] st_mid, output logic irq_stop);
      lat = 0;
      while (line_out !== 1'b0 && lat < lim + 4) begin
         @(negedge clk);
         lat++;
      end
      repeat (t / 2) @(negedge clk);
      for (int k = 0; k < 11; k++) begin
         bits[k] = line_out;
         if (k == 5) begin
            hread(2'd3, st_mid);
            repeat (t - 2) @(negedge clk);
         end else if (k == 9) begin
            repeat (t / 2 + t / 8) @(negedge clk);
            card_line = inject ? 1'b0 : 1'b1;
            repeat (3 * t / 8) @(negedge clk);
         end else if (k == 10) begin
            irq_stop = tx_irq;
            repeat (3 * t / 8) @(negedge clk);
            card_line = 1'b1;
         end else begin
            repeat (t) @(negedge clk);
         end
      end
   endtask

   task automatic send_rx(input int t, input logic [7:0] d, input bit odd,
                          input bit flip, output logic mid_line);
      card_line = 1'b0;
      repeat (t) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         card_line = d[i];
         repeat (t) @(negedge clk);
      end
      card_line = (^d) ^ odd ^ flip;
      repeat (t) @(negedge clk);
      card_line = 1'b1;
      repeat (t / 2) @(negedge clk);
      mid_line = line_out;
      repeat (t / 2 + t / 4) @(negedge clk);
   endtask

   task automatic tx_case(input string tag, input int n, input int dv,
                          input logic [7:0] d, input bit odd, input bit inject,
                          input logic [7:0] exp_mid);
      logic [10:0] bits;
      int lat;
      logic [7:0] st;
      logic irq_stop;
      int t = 16 * (n + 1) * dv;
      arm = 1;
      hwrite(2'd0, d);
      capture(t, (n + 1) * dv, inject, bits, lat, st, irq_stop);
      check(bits == frame_of(d, odd), {tag, " R2 frame bits"}, bits, frame_of(d, odd));
      check(lat <= (n + 1) * dv + 1, {tag, " R3 start latency"}, lat, (n + 1) * dv + 1);
      check(st == exp_mid, {tag, " R4 mid-frame status"}, st, exp_mid);
      check(irq_stop == 1'b0 || exp_mid[5], {tag, " R5 no early done irq"}, irq_stop, 0);
      repeat (t / 4) @(negedge clk);
      check(low_width == first_low(d, t), {tag, " R1 bit time"}, low_width, first_low(d, t));
      check(tx_irq == 1'b1, {tag, " R5 irq after frame"}, tx_irq, 1);
   endtask

   initial begin
      logic [7:0] st, rd;
      logic mid;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      hread(2'd3, st);
      check(st == 8'h03, "R11 status after reset", st, 8'h03);
      check(line_out == 1'b1, "R11 line idle", line_out, 1);
      check(tx_irq == 1'b0 && rx_irq == 1'b0, "R11 irqs low", {tx_irq, rx_irq}, 0);

      // divide-by-1, n=1, even, cause = frame done
      hwrite(2'd2, 8'd1);
      hwrite(2'd1, 8'h09);
      tx_case("A", 1, 1, 8'hA5, 1'b0, 1'b0, 8'h01);
      hread(2'd3, st);
      check(st == 8'h23, "A R6 no error signal, R4 reg empty", st, 8'h23);

      // R10 clear by status write
      hwrite(2'd3, 8'h20);
      check(tx_irq == 1'b0, "R10 tx irq write clear", tx_irq, 0);

      // divide-by-8, n=0, odd, cause = buffer empty
      hwrite(2'd2, 8'd0);
      hwrite(2'd1, 8'h15);
      tx_case("B", 0, 8, 8'h3C, 1'b1, 1'b0, 8'h21);
      tx_irq_ack = 1'b1;
      @(negedge clk);
      tx_irq_ack = 1'b0;
      check(tx_irq == 1'b0, "R10 tx irq ack", tx_irq, 0);

      // divide-by-32, n=0, even, cause = done, far end signals error
      hwrite(2'd1, 8'h29);
      tx_case("C", 0, 32, 8'h01, 1'b0, 1'b1, 8'h01);
      hread(2'd3, st);
      check(st == 8'h33, "C R6 error signal caught", st, 8'h33);
      hwrite(2'd3, 8'h30);
      hread(2'd3, st);
      check(st == 8'h03, "C R6 flag write clear", st, 8'h03);

      // receive, divide-by-1, n=1, even, good frame
      hwrite(2'd2, 8'd1);
      hwrite(2'd1, 8'h02);
      send_rx(32, 8'h5A, 1'b0, 1'b0, mid);
      check(mid == 1'b1, "R8 good frame no drive", mid, 1);
      check(rx_irq == 1'b1, "R7 rx irq", rx_irq, 1);
      hread(2'd3, st);
      check(st == 8'h47, "R7 rx done status", st, 8'h47);
      hread(2'd0, rd);
      check(rd == 8'h5A, "R7 rx data", rd, 8'h5A);
      hread(2'd3, st);
      check(st == 8'h43, "R7 read clears done", st, 8'h43);
      rx_irq_ack = 1'b1;
      @(negedge clk);
      rx_irq_ack = 1'b0;
      check(rx_irq == 1'b0, "R10 rx irq ack", rx_irq, 0);

      // odd parity, bad frame
      hwrite(2'd1, 8'h06);
      send_rx(32, 8'hC3, 1'b1, 1'b1, mid);
      check(mid == 1'b0, "R8 bad parity drives line low", mid, 0);
      hread(2'd3, st);
      check(st == 8'h4F, "R8 sticky parity error", st, 8'h4F);
      hread(2'd0, rd);
      check(rd == 8'hC3, "R8 data delivered", rd, 8'hC3);
      hwrite(2'd3, 8'h48);
      hread(2'd3, st);
      check(st == 8'h03, "R8 R10 write clears", st, 8'h03);

      // odd parity, good frame
      send_rx(32, 8'h81, 1'b1, 1'b0, mid);
      check(mid == 1'b1, "R8 odd good no drive", mid, 1);
      hread(2'd0, rd);
      check(rd == 8'h81, "R7 odd data", rd, 8'h81);
      hwrite(2'd3, 8'h40);

      // glitch shorter than half a bit
      card_line = 1'b0;
      repeat (8) @(negedge clk);
      card_line = 1'b1;
      repeat (12 * 32) @(negedge clk);
      hread(2'd3, st);
      check(st == 8'h03, "R9 glitch ignored", st, 8'h03);
      check(rx_irq == 1'b0, "R9 no rx irq", rx_irq, 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule